// File: doc/BRIEF.md
# Register Wakeup Scoreboard with Dependents

This block tracks whether each physical register holds a valid value and which waiting instructions depend on it. Integer and floating-point registers share one flat index space. Integer register k sits at index k. Floating-point register k sits at index NUM_INT + k. Each interface takes a class bit and a local index, and the block maps that pair to the flat index itself.

A rename stage marks a destination register as pending through the allocate port. A dispatch stage places an instruction into a consumer slot with up to NUM_SRC source operands. Each source that is still pending at that moment is recorded on that register's dependent vector, which holds one bit per slot. When an execution unit broadcasts a completed destination register, every slot recorded on it is woken in the same cycle, and the register's vector is emptied. Each slot has a ready output that a downstream selector can read directly.

Slots are released through the free port. Freeing a slot removes it from every register's vector, so the slot can be reused with no stale dependences.

Top module: `wakeup_scoreboard`

## Requirements
- R1: After reset every register reads ready on `reg_ready_o`, and no slot reads ready on `slot_ready_o`.
- R2: A class bit of 0 with local index k addresses flat register k. A class bit of 1 with local index k addresses flat register NUM_INT + k, where NUM_INT is 8 by default.
- R3: An allocate clears the addressed register's bit in `reg_ready_o` from the next cycle on. A completion sets that bit from the next cycle on.
- R4: A dispatch whose valid sources all read ready makes the slot ready in the next cycle. A source whose valid bit is 0 is ignored, whatever its index.
- R5: A slot with a pending source stays not-ready until that register completes. It becomes ready in the cycle after the completion.
- R6: One completion wakes every slot waiting on that register in the same cycle, and then empties that register's dependent vector. A later allocate of the register does not pull a woken slot back to not-ready.
- R7: A slot with two pending sources becomes ready only after both have completed, in either order. When both sources name the same register, one completion wakes the slot.
- R8: A completion broadcast in the same cycle as a dispatch counts as already ready for that dispatch's sources.
- R9: A source that reads ready at dispatch is not recorded on its register. A later allocate of that register leaves the slot ready.
- R10: Freeing a slot drops its ready output in the next cycle and removes the slot from every register's dependent vector. A slot that is freed and then redispatched with no valid sources is ready at once.
- R11: When allocate and completion name the same register in the same cycle, the allocate wins and the register ends pending.
- R12: When free and dispatch name the same slot in the same cycle, the dispatch wins and the slot holds the new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| alloc_valid_i | input | 1 | Mark a destination register pending |
| alloc_fp_i | input | 1 | Class of the allocated register (1 = floating point) |
| alloc_idx_i | input | LOC_W | Local index of the allocated register |
| disp_valid_i | input | 1 | Place an instruction into a slot |
| disp_slot_i | input | SLOT_W | Target slot |
| disp_src_valid_i | input | NUM_SRC | Per-source valid bits |
| disp_src_fp_i | input | NUM_SRC | Per-source class bits |
| disp_src_idx_i | input | NUM_SRC*LOC_W | Per-source local indices; source k sits in bits [k*LOC_W +: LOC_W] |
| cmp_valid_i | input | 1 | Completion broadcast |
| cmp_fp_i | input | 1 | Class of the completed register |
| cmp_idx_i | input | LOC_W | Local index of the completed register |
| free_valid_i | input | 1 | Release a slot |
| free_slot_i | input | SLOT_W | Slot to release |
| slot_ready_o | output | NUM_SLOTS | Slot is occupied and all its valid sources are ready |
| reg_ready_o | output | NUM_REGS | Per flat register ready bit |

## Verification
The checker assumes the following about the inputs:
- Local indices are in range for their class.
- A dispatch never targets an occupied slot unless that slot is freed in the same cycle.
- A register is allocated only when no slot still waits on it.

The stimulus keeps to these rules. It frees slots before reusing them, and it re-allocates only registers whose waiters have already been woken. Given these rules, the checker can tie every rise of a slot's ready output to a dispatch or a completion in the previous cycle, and every fall to a free or a dispatch.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic {
    RC_INT = 1'b0,
    RC_FP  = 1'b1
  } reg_class_e;

  // Flat index: integer registers first, floating point after them.
  function automatic int unsigned flat_of(input logic fp, input int unsigned idx,
                                          input int unsigned n_int);
    return (fp == RC_FP) ? (n_int + idx) : idx;
  endfunction

endpackage

// File: rtl/wk_rst_sync.sv
module wk_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/wk_reg_map.sv
module wk_reg_map import wk_pkg::*; #(
  parameter int unsigned NUM_INT = 8,
  parameter int unsigned LOC_W   = 3,
  parameter int unsigned REG_W   = 4
)(
  input  logic             fp_i,
  input  logic [LOC_W-1:0] idx_i,
  output logic [REG_W-1:0] flat_o
);
  always_comb begin
    flat_o = REG_W'(flat_of(fp_i, int'(idx_i), NUM_INT));
  end
endmodule

// File: rtl/wk_ready_table.sv
module wk_ready_table #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned REG_W    = 4
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_valid_i,
  input  logic [REG_W-1:0]    alloc_reg_i,
  input  logic                cmp_valid_i,
  input  logic [REG_W-1:0]    cmp_reg_i,
  output logic [NUM_REGS-1:0] ready_o
);
  logic [NUM_REGS-1:0] rdy_q, rdy_d;
  logic                rdy_en;

  always_comb begin
    rdy_en = alloc_valid_i | cmp_valid_i;
    rdy_d  = rdy_q;
    for (int r = 0; r < int'(NUM_REGS); r++) begin
      if (cmp_valid_i && cmp_reg_i == REG_W'(r))     rdy_d[r] = 1'b1;
      // allocate applied last: it wins a same-register collision
      if (alloc_valid_i && alloc_reg_i == REG_W'(r)) rdy_d[r] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdy_q <= '1;
    else if (rdy_en) rdy_q <= rdy_d;
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/wk_dep_matrix.sv
module wk_dep_matrix #(
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned REG_W     = 4,
  parameter int unsigned SLOT_W    = 3
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_valid_i,
  input  logic [REG_W-1:0]     cmp_reg_i,
  input  logic                 disp_valid_i,
  input  logic [SLOT_W-1:0]    disp_slot_i,
  input  logic                 need_i,
  input  logic [REG_W-1:0]     src_reg_i,
  input  logic                 free_valid_i,
  input  logic [SLOT_W-1:0]    free_slot_i,
  output logic [NUM_SLOTS-1:0] wait_o
);
  logic [NUM_REGS-1:0][NUM_SLOTS-1:0] dep_q, dep_d;
  logic [NUM_SLOTS-1:0]               clr_slots;
  logic                               dep_en;

  always_comb begin
    dep_en    = cmp_valid_i | disp_valid_i | free_valid_i;
    clr_slots = '0;
    if (disp_valid_i) clr_slots[disp_slot_i] = 1'b1;
    if (free_valid_i) clr_slots[free_slot_i] = 1'b1;
    for (int r = 0; r < int'(NUM_REGS); r++) begin
      dep_d[r] = dep_q[r] & ~clr_slots;
      if (need_i && src_reg_i == REG_W'(r))      dep_d[r][disp_slot_i] = 1'b1;
      if (cmp_valid_i && cmp_reg_i == REG_W'(r)) dep_d[r] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dep_q <= '0;
    else if (dep_en) dep_q <= dep_d;
  end

  always_comb begin
    wait_o = '0;
    for (int r = 0; r < int'(NUM_REGS); r++) wait_o = wait_o | dep_q[r];
  end
endmodule

// File: rtl/wk_slot_table.sv
module wk_slot_table #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned NUM_SRC   = 2,
  parameter int unsigned SLOT_W    = 3
)(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              disp_valid_i,
  input  logic [SLOT_W-1:0]                 disp_slot_i,
  input  logic                              free_valid_i,
  input  logic [SLOT_W-1:0]                 free_slot_i,
  input  logic [NUM_SRC-1:0][NUM_SLOTS-1:0] wait_i,
  output logic [NUM_SLOTS-1:0]              ready_o
);
  logic [NUM_SLOTS-1:0] occ_q, occ_d, busy;
  logic                 occ_en;

  always_comb begin
    occ_en = disp_valid_i | free_valid_i;
    occ_d  = occ_q;
    if (free_valid_i) occ_d[free_slot_i] = 1'b0;
    // dispatch applied last: it wins a same-slot collision
    if (disp_valid_i) occ_d[disp_slot_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  always_comb begin
    busy = '0;
    for (int k = 0; k < int'(NUM_SRC); k++) busy = busy | wait_i[k];
    ready_o = occ_q & ~busy;
  end
endmodule

// File: rtl/wakeup_scoreboard.sv
module wakeup_scoreboard #(
  parameter int unsigned NUM_INT   = 8,
  parameter int unsigned NUM_FP    = 8,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned NUM_SRC   = 2,
  localparam int unsigned NUM_REGS = NUM_INT + NUM_FP,
  localparam int unsigned LOC_W    = (NUM_INT > NUM_FP) ? $clog2(NUM_INT) : $clog2(NUM_FP),
  localparam int unsigned REG_W    = $clog2(NUM_REGS),
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid_i,
  input  logic                     alloc_fp_i,
  input  logic [LOC_W-1:0]         alloc_idx_i,
  input  logic                     disp_valid_i,
  input  logic [SLOT_W-1:0]        disp_slot_i,
  input  logic [NUM_SRC-1:0]       disp_src_valid_i,
  input  logic [NUM_SRC-1:0]       disp_src_fp_i,
  input  logic [NUM_SRC*LOC_W-1:0] disp_src_idx_i,
  input  logic                     cmp_valid_i,
  input  logic                     cmp_fp_i,
  input  logic [LOC_W-1:0]         cmp_idx_i,
  input  logic                     free_valid_i,
  input  logic [SLOT_W-1:0]        free_slot_i,
  output logic [NUM_SLOTS-1:0]     slot_ready_o,
  output logic [NUM_REGS-1:0]      reg_ready_o
);
  logic                              rst_n_sync;
  logic [REG_W-1:0]                  alloc_reg, cmp_reg;
  logic [NUM_SRC-1:0][REG_W-1:0]     src_reg;
  logic [NUM_SRC-1:0]                need;
  logic [NUM_SRC-1:0][NUM_SLOTS-1:0] wait_vec;

  wk_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_sync));

  wk_reg_map #(.NUM_INT(NUM_INT), .LOC_W(LOC_W), .REG_W(REG_W)) u_alloc_map (
    .fp_i(alloc_fp_i), .idx_i(alloc_idx_i), .flat_o(alloc_reg));

  wk_reg_map #(.NUM_INT(NUM_INT), .LOC_W(LOC_W), .REG_W(REG_W)) u_cmp_map (
    .fp_i(cmp_fp_i), .idx_i(cmp_idx_i), .flat_o(cmp_reg));

  wk_ready_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_ready (
    .clk(clk), .rst_n(rst_n_sync),
    .alloc_valid_i(alloc_valid_i), .alloc_reg_i(alloc_reg),
    .cmp_valid_i(cmp_valid_i), .cmp_reg_i(cmp_reg),
    .ready_o(reg_ready_o));

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    wk_reg_map #(.NUM_INT(NUM_INT), .LOC_W(LOC_W), .REG_W(REG_W)) u_src_map (
      .fp_i(disp_src_fp_i[k]), .idx_i(disp_src_idx_i[k*LOC_W +: LOC_W]),
      .flat_o(src_reg[k]));

    // Pending unless ready now or completing this very cycle.
    assign need[k] = disp_valid_i & disp_src_valid_i[k]
                   & ~(reg_ready_o[src_reg[k]] | (cmp_valid_i & (cmp_reg == src_reg[k])));

    wk_dep_matrix #(.NUM_REGS(NUM_REGS), .NUM_SLOTS(NUM_SLOTS),
                    .REG_W(REG_W), .SLOT_W(SLOT_W)) u_dep (
      .clk(clk), .rst_n(rst_n_sync),
      .cmp_valid_i(cmp_valid_i), .cmp_reg_i(cmp_reg),
      .disp_valid_i(disp_valid_i), .disp_slot_i(disp_slot_i),
      .need_i(need[k]), .src_reg_i(src_reg[k]),
      .free_valid_i(free_valid_i), .free_slot_i(free_slot_i),
      .wait_o(wait_vec[k]));
  end

  wk_slot_table #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC), .SLOT_W(SLOT_W)) u_slots (
    .clk(clk), .rst_n(rst_n_sync),
    .disp_valid_i(disp_valid_i), .disp_slot_i(disp_slot_i),
    .free_valid_i(free_valid_i), .free_slot_i(free_slot_i),
    .wait_i(wait_vec), .ready_o(slot_ready_o));
endmodule

// File: rtl/wk_sb_chk.sv
module wk_sb_chk import wk_pkg::*; #(
  parameter int unsigned NUM_INT   = 8,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned NUM_SRC   = 2,
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned LOC_W     = 3,
  parameter int unsigned REG_W     = 4,
  parameter int unsigned SLOT_W    = 3
)(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     alloc_valid_i,
  input logic                     alloc_fp_i,
  input logic [LOC_W-1:0]         alloc_idx_i,
  input logic                     disp_valid_i,
  input logic [SLOT_W-1:0]        disp_slot_i,
  input logic [NUM_SRC-1:0]       disp_src_valid_i,
  input logic [NUM_SRC-1:0]       disp_src_fp_i,
  input logic [NUM_SRC*LOC_W-1:0] disp_src_idx_i,
  input logic                     cmp_valid_i,
  input logic                     cmp_fp_i,
  input logic [LOC_W-1:0]         cmp_idx_i,
  input logic                     free_valid_i,
  input logic [SLOT_W-1:0]        free_slot_i,
  input logic [NUM_SLOTS-1:0]     slot_ready_o,
  input logic [NUM_REGS-1:0]      reg_ready_o
);
  logic [REG_W-1:0]   a_flat, c_flat;
  logic [NUM_SRC-1:0] src_ok;

  always_comb begin
    a_flat = REG_W'(flat_of(alloc_fp_i, int'(alloc_idx_i), NUM_INT));
    c_flat = REG_W'(flat_of(cmp_fp_i, int'(cmp_idx_i), NUM_INT));
    for (int k = 0; k < int'(NUM_SRC); k++) begin
      logic [REG_W-1:0] f;
      f = REG_W'(flat_of(disp_src_fp_i[k], int'(disp_src_idx_i[k*LOC_W +: LOC_W]), NUM_INT));
      src_ok[k] = !disp_src_valid_i[k] || reg_ready_o[f] || (cmp_valid_i && c_flat == f);
    end
  end

  // R3 R11
  alloc_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid_i |=> !reg_ready_o[$past(a_flat)]);

  // R3
  cmp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_i && !(alloc_valid_i && a_flat == c_flat)) |=> reg_ready_o[$past(c_flat)]);

  // R4 R8
  disp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_i && (&src_ok)) |=> slot_ready_o[$past(disp_slot_i)]);

  // R10
  free_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid_i && !(disp_valid_i && disp_slot_i == free_slot_i))
      |=> !slot_ready_o[$past(free_slot_i)]);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    // R5
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_ready_o[s]) |-> ($past(disp_valid_i && disp_slot_i == SLOT_W'(s)) || $past(cmp_valid_i)));
    // R10
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slot_ready_o[s]) |-> $past(free_valid_i || disp_valid_i));
  end
endmodule

bind wakeup_scoreboard wk_sb_chk #(
  .NUM_INT(NUM_INT), .NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC), .NUM_REGS(NUM_REGS),
  .LOC_W(LOC_W), .REG_W(REG_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_sync),
  .alloc_valid_i(alloc_valid_i), .alloc_fp_i(alloc_fp_i), .alloc_idx_i(alloc_idx_i),
  .disp_valid_i(disp_valid_i), .disp_slot_i(disp_slot_i),
  .disp_src_valid_i(disp_src_valid_i), .disp_src_fp_i(disp_src_fp_i),
  .disp_src_idx_i(disp_src_idx_i),
  .cmp_valid_i(cmp_valid_i), .cmp_fp_i(cmp_fp_i), .cmp_idx_i(cmp_idx_i),
  .free_valid_i(free_valid_i), .free_slot_i(free_slot_i),
  .slot_ready_o(slot_ready_o), .reg_ready_o(reg_ready_o)
);

// File: tb/tb_wakeup_scoreboard.sv
`timescale 1ns/1ps
module tb_wakeup_scoreboard;
  localparam int NI = 8;

  logic clk, rst_n;
  logic       alloc_valid_i, alloc_fp_i;
  logic [2:0] alloc_idx_i;
  logic       disp_valid_i;
  logic [2:0] disp_slot_i;
  logic [1:0] disp_src_valid_i, disp_src_fp_i;
  logic [5:0] disp_src_idx_i;
  logic       cmp_valid_i, cmp_fp_i;
  logic [2:0] cmp_idx_i;
  logic       free_valid_i;
  logic [2:0] free_slot_i;
  logic [7:0] slot_ready_o;
  logic [15:0] reg_ready_o;

  wakeup_scoreboard dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct { string tag; logic [7:0] slots; logic [15:0] regs; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  bit mrdy[16];
  bit mocc[8];
  bit mwait[8][2];
  int msrc[8][2];

  function automatic int fl(bit fp, int idx);
    return fp ? NI + idx : idx;
  endfunction

  task automatic idle();
    alloc_valid_i = 0; alloc_fp_i = 0; alloc_idx_i = 0;
    disp_valid_i = 0; disp_slot_i = 0; disp_src_valid_i = 0;
    disp_src_fp_i = 0; disp_src_idx_i = 0;
    cmp_valid_i = 0; cmp_fp_i = 0; cmp_idx_i = 0;
    free_valid_i = 0; free_slot_i = 0;
  endtask

  task automatic alloc(bit fp, int idx);
    alloc_valid_i = 1; alloc_fp_i = fp; alloc_idx_i = 3'(idx);
  endtask
  task automatic compl(bit fp, int idx);
    cmp_valid_i = 1; cmp_fp_i = fp; cmp_idx_i = 3'(idx);
  endtask
  task automatic freeslot(int s);
    free_valid_i = 1; free_slot_i = 3'(s);
  endtask
  task automatic disp(int s, bit v0, bit fp0, int i0, bit v1, bit fp1, int i1);
    disp_valid_i = 1; disp_slot_i = 3'(s);
    disp_src_valid_i = {v1, v0}; disp_src_fp_i = {fp1, fp0};
    disp_src_idx_i = {3'(i1), 3'(i0)};
  endtask

  // Driver: update model from current inputs, clock, push expectation.
  task automatic step(string tag);
    exp_t e;
    int cf, af;
    bit nw[2];
    int nf[2];
    cf = fl(cmp_fp_i, int'(cmp_idx_i));
    af = fl(alloc_fp_i, int'(alloc_idx_i));
    for (int k = 0; k < 2; k++) begin
      nf[k] = fl(disp_src_fp_i[k], int'(disp_src_idx_i[k*3 +: 3]));
      nw[k] = disp_src_valid_i[k] && !(mrdy[nf[k]] || (cmp_valid_i && cf == nf[k]));
    end
    if (cmp_valid_i)
      for (int s = 0; s < 8; s++)
        for (int k = 0; k < 2; k++)
          if (mwait[s][k] && msrc[s][k] == cf) mwait[s][k] = 0;
    if (free_valid_i) begin
      mocc[free_slot_i] = 0; mwait[free_slot_i][0] = 0; mwait[free_slot_i][1] = 0;
    end
    if (disp_valid_i) begin
      mocc[disp_slot_i] = 1;
      for (int k = 0; k < 2; k++) begin
        mwait[disp_slot_i][k] = nw[k]; msrc[disp_slot_i][k] = nf[k];
      end
    end
    if (cmp_valid_i) mrdy[cf] = 1;
    if (alloc_valid_i) mrdy[af] = 0;
    e.tag = tag;
    for (int s = 0; s < 8; s++) e.slots[s] = mocc[s] && !mwait[s][0] && !mwait[s][1];
    for (int r = 0; r < 16; r++) e.regs[r] = mrdy[r];
    @(posedge clk);
    exp_q.push_back(e);
    @(negedge clk);
    idle();
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (slot_ready_o !== e.slots || reg_ready_o !== e.regs) begin
        fails++;
        $display("FAIL %s: slots=%b regs=%b expected slots=%b regs=%b",
                 e.tag, slot_ready_o, reg_ready_o, e.slots, e.regs);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) mrdy[r] = 1;
    for (int s = 0; s < 8; s++) begin
      mocc[s] = 0; mwait[s][0] = 0; mwait[s][1] = 0; msrc[s][0] = 0; msrc[s][1] = 0;
    end
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    step("R1 reset state");
    alloc(0, 3); step("R3 alloc int3");
    alloc(1, 3); step("R2 fp3 maps to flat 11");
    disp(0, 1, 0, 5, 0, 0, 3); step("R4 ready sources, invalid source ignored");
    disp(1, 1, 0, 3, 0, 0, 0); step("R5 dispatch on pending int3");
    step("R5 still waiting");
    compl(0, 3); step("R5 wake after completion");
    compl(1, 3); step("R3 complete fp3");
    alloc(1, 2); step("R3 alloc fp2");
    disp(2, 1, 1, 2, 0, 0, 0); step("R6 slot2 waits on fp2");
    disp(3, 0, 0, 0, 1, 1, 2); step("R6 slot3 waits on fp2");
    disp(4, 1, 1, 2, 1, 1, 2); step("R7 slot4 both sources fp2");
    compl(1, 2); step("R6 one completion wakes all");
    alloc(1, 2); step("R6 list cleared after wake");
    compl(1, 2); step("R6 restore fp2");
    alloc(0, 6); step("R7 alloc int6");
    alloc(0, 7); step("R7 alloc int7");
    disp(5, 1, 0, 6, 1, 0, 7); step("R7 two pending sources");
    compl(0, 7); step("R7 first of two done");
    compl(0, 6); step("R7 both done");
    alloc(0, 1); step("R8 alloc int1");
    disp(6, 1, 0, 1, 0, 0, 0); compl(0, 1); step("R8 same-cycle completion bypass");
    alloc(0, 1); step("R8 bypassed source not recorded");
    disp(7, 1, 0, 2, 0, 0, 0); step("R9 dispatch on ready int2");
    alloc(0, 2); step("R9 later alloc leaves slot ready");
    freeslot(0); step("R10 free slot0 drops ready");
    alloc(0, 4); step("R10 alloc int4");
    disp(0, 1, 0, 4, 0, 0, 0); step("R10 slot0 waits on int4");
    freeslot(0); step("R10 free waiting slot0");
    disp(0, 0, 0, 0, 0, 0, 0); step("R10 redispatch slot0 no stale dependence");
    compl(0, 4); step("R10 complete int4");
    alloc(1, 5); compl(1, 5); step("R11 alloc wins over completion");
    compl(1, 5); step("R11 later completion sets fp5");
    alloc(1, 6); step("R12 alloc fp6");
    freeslot(1); disp(1, 1, 1, 6, 0, 0, 0); step("R12 dispatch wins over free");
    compl(1, 6); step("R12 new instruction wakes");
    compl(0, 1); compl(0, 2); step("R3 complete int2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule